// File: doc/BRIEF.md
# GPIO Port with Edge Interrupts

This block is a memory-mapped general-purpose port for four pins. It has direction, data, interrupt-enable and interrupt-pending registers on a simple single-cycle register bus. Each register is 16 bits wide, and the four port bits sit in bit positions 11 down to 8. Pin 0 is bit 8 and pin 3 is bit 11. The data register feeds an output latch, and the direction register drives each pin's output enable. Reads of the data register follow each pin's direction.

Every pin passes through a two-flop synchronizer. A falling edge on a pin that is configured as an input sets a sticky pending bit. Software clears a pending bit by writing a one to it. The interrupt output is the OR of all pending bits whose enable bit is set.

A mode input hands pin 0 to a refresh-request function. In that mode pin 0 is treated as an input, its falling edges set no pending bit, and its synchronized level appears on a dedicated output.

Top module: `gpio_edge_port`

## Requirements
- R1: The direction register is at offset 0. A bit value of 1 makes the pin an output, and `pin_oe` follows the bit. Reset clears the register, so all pins start as inputs.
- R2: Every write to offset 2 updates the output latch, whatever the pin directions are. `pin_out` always shows the latch.
- R3: A read of offset 2 returns the latch bit for output pins and the synchronized pin level for input pins.
- R4: Each pin level is synchronized through two flops. A level applied before clock edge k is visible in reads after edge k+1.
- R5: A falling edge on an input pin sets its pending bit at offset 6. The edge is seen after edge k+1 and the bit is set at edge k+2. Rising edges and edges on output pins set nothing. Reset clears all pending bits.
- R6: Writing 1 to a pending bit clears it, and writing 0 has no effect. If an edge and a clear arrive in the same cycle, the bit stays set.
- R7: The enable register is at offset 4, and a bit value of 1 lets that pin's pending bit through. It resets to 0. `irq` is the OR of pending AND enable.
- R8: Bits 15:12 and 7:0 always read as 0, and offsets 1, 3, 5 and 7 read as 0. Writes to those bits or offsets have no effect.
- R9: While `refresh_mode` is 1, pin 0 behaves as an input. Its `pin_oe` is low, its reads return the pin level, its falling edges do not set pending bit 0, and `refresh_req` carries its synchronized level. While `refresh_mode` is 0, `refresh_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| pin_in | input | 4 | Pad input levels |
| pin_out | output | 4 | Output latch to the pads |
| pin_oe | output | 4 | Pad output enables |
| refresh_mode | input | 1 | Hands pin 0 to the refresh-request function |
| refresh_req | output | 1 | Synchronized pin 0 level while in refresh mode |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives static levels on pins with mixed directions. This separates a latch read from a pin read and shows the two-cycle synchronizer delay. It drives falling and rising edges on input pins and on output pins, to tell real edge detection apart from plain level or direction sensing. It times a clear to land in the same cycle as a new edge, which checks the set-over-clear priority. It toggles pin 0 in refresh mode and runs a long random mix of writes, pin activity and mode changes. Every output is compared each cycle with a behavioural reference model.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR  = 3'd0,
        SEL_DATA = 3'd2,
        SEL_MASK = 3'd4,
        SEL_PEND = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic hits(bus_req_t r, reg_sel_e s);
        return r.we && (r.addr == s);
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic stage_a, stage_b;
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_a <= 1'b0;
                stage_b <= 1'b0;
            end else begin
                stage_a <= raw[i];
                stage_b <= stage_a;
            end
        end
        assign level[i] = stage_b;
    end
endmodule

// File: rtl/gpio_fall_irq.sv
module gpio_fall_irq #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    input  logic [W-1:0] arm,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] mask,
    output logic [W-1:0] pend,
    output logic         irq
);
    logic [W-1:0] prev;
    logic [W-1:0] fall;

    assign fall = prev & ~level & arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            pend <= '0;
        end else begin
            prev <= level;
            pend <= (pend & ~clr) | fall;
        end
    end

    assign irq = |(pend & mask);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_edge_pkg::*;
#(
    parameter int W   = 4,
    parameter int LSB = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [W-1:0]      level,
    input  logic [W-1:0]      dir_eff,
    input  logic [W-1:0]      pend,
    output logic [W-1:0]      dir,
    output logic [W-1:0]      latch,
    output logic [W-1:0]      mask,
    output logic [W-1:0]      clr,
    output logic [DATA_W-1:0] rdata
);
    localparam int MSB = LSB + W - 1;

    logic [W-1:0] field;
    assign field = req.wdata[MSB:LSB];
    assign clr   = hits(req, SEL_PEND) ? field : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir   <= '0;
            latch <= '0;
            mask  <= '0;
        end else begin
            if (hits(req, SEL_DIR))  dir   <= field;
            if (hits(req, SEL_DATA)) latch <= field;
            if (hits(req, SEL_MASK)) mask  <= field;
        end
    end

    always_comb begin
        rdata = '0;
        case (req.addr)
            SEL_DIR:  rdata[MSB:LSB] = dir;
            SEL_DATA: rdata[MSB:LSB] = (latch & dir_eff) | (level & ~dir_eff);
            SEL_MASK: rdata[MSB:LSB] = mask;
            SEL_PEND: rdata[MSB:LSB] = pend;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int NPINS       = 4,
    parameter int PIN_LSB     = 8,
    parameter int REFRESH_PIN = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    input  logic              refresh_mode,
    output logic              refresh_req,
    output logic              irq
);
    bus_req_t         req;
    logic [NPINS-1:0] level, dir, dir_eff, latch, mask, clr, pend, rsel;

    assign req = '{we: bus_we, addr: bus_addr, wdata: bus_wdata};

    always_comb begin
        rsel = '0;
        rsel[REFRESH_PIN] = refresh_mode;
    end

    assign dir_eff     = dir & ~rsel;
    assign pin_oe      = dir_eff;
    assign pin_out     = latch;
    assign refresh_req = refresh_mode & level[REFRESH_PIN];

    gpio_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst(rst), .raw(pin_in), .level(level)
    );

    gpio_regs #(.W(NPINS), .LSB(PIN_LSB)) u_regs (
        .clk(clk), .rst(rst), .req(req), .level(level), .dir_eff(dir_eff),
        .pend(pend), .dir(dir), .latch(latch), .mask(mask), .clr(clr),
        .rdata(bus_rdata)
    );

    gpio_fall_irq #(.W(NPINS)) u_irq (
        .clk(clk), .rst(rst), .level(level), .arm(~dir_eff & ~rsel),
        .clr(clr), .mask(mask), .pend(pend), .irq(irq)
    );
endmodule

module gpio_edge_port_chk
    import gpio_edge_pkg::*;
#(
    parameter int NPINS       = 4,
    parameter int PIN_LSB     = 8,
    parameter int REFRESH_PIN = 0
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              refresh_mode,
    input logic              refresh_req,
    input logic              irq
);
    localparam int MSB = PIN_LSB + NPINS - 1;

    assert_dir_write_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == SEL_DIR) |=>
            pin_oe[NPINS-1:1] == $past(bus_wdata[MSB:PIN_LSB+1]));

    assert_latch_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == SEL_DATA) |=> pin_out == $past(bus_wdata[MSB:PIN_LSB]));

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == SEL_MASK && bus_wdata[MSB:PIN_LSB] == '0) |=> !irq);

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:MSB+1] == '0 && bus_rdata[PIN_LSB-1:0] == '0);

    assert_refresh_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !refresh_mode |-> !refresh_req);

    assert_refresh_input_R9: assert property (@(posedge clk) disable iff (rst)
        refresh_mode |-> !pin_oe[REFRESH_PIN]);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(
    .NPINS(NPINS), .PIN_LSB(PIN_LSB), .REFRESH_PIN(REFRESH_PIN)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .refresh_mode(refresh_mode), .refresh_req(refresh_req),
    .irq(irq)
);

// File: tb/test_gpio_edge_port.sv
`timescale 1ns/1ps
module test_gpio_edge_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  pin_in = '0;
    logic [3:0]  pin_out, pin_oe;
    logic        refresh_mode = 1'b0;
    logic        refresh_req, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit model_on = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_edge_port i_gpio_edge_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .refresh_mode(refresh_mode),
        .refresh_req(refresh_req), .irq(irq)
    );

    // Behavioural reference: registers plus a queue of recent pin samples.
    bit [3:0] m_dir, m_lat, m_msk, m_pnd;
    bit [3:0] hist[$];

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic bit [3:0] rmask();
        return refresh_mode ? 4'b0001 : 4'b0000;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_dir = 0; m_lat = 0; m_msk = 0; m_pnd = 0;
            hist = '{4'd0, 4'd0, 4'd0};
            model_on = 1;
        end else if (model_on) begin
            bit [3:0] cur, old, arm, fall, clrv, f;
            cur  = hist[1];
            old  = hist[2];
            arm  = ~(m_dir & ~rmask()) & ~rmask();
            fall = old & ~cur & arm;
            f    = bus_wdata[11:8];
            clrv = (bus_we && bus_addr == 3'd6) ? f : 4'd0;
            m_pnd = (m_pnd & ~clrv) | fall;
            if (bus_we && bus_addr == 3'd0) m_dir = f;
            if (bus_we && bus_addr == 3'd2) m_lat = f;
            if (bus_we && bus_addr == 3'd4) m_msk = f;
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (model_on && !done) begin
            bit [3:0]  de;
            bit [15:0] er;
            de = m_dir & ~rmask();
            er = 16'h0;
            case (bus_addr)
                3'd0: er[11:8] = m_dir;
                3'd2: er[11:8] = (m_lat & de) | (hist[1] & ~de);
                3'd4: er[11:8] = m_msk;
                3'd6: er[11:8] = m_pnd;
                default: er = 16'h0;
            endcase
            chk("R1/R9 pin_oe", {12'd0, pin_oe}, {12'd0, de});
            chk("R2 pin_out", {12'd0, pin_out}, {12'd0, m_lat});
            chk("R7 irq", {15'd0, irq}, {15'd0, |(m_pnd & m_msk)});
            chk("R9 refresh_req", {15'd0, refresh_req}, {15'd0, refresh_mode & hist[1][0]});
            chk("R8 reserved bits", bus_rdata & 16'hF0FF, 16'h0);
            case (bus_addr)
                3'd0: chk("R1 dir read", bus_rdata, er);
                3'd2: chk("R3/R4 data read", bus_rdata, er);
                3'd4: chk("R7 mask read", bus_rdata, er);
                3'd6: chk("R5/R6 pending read", bus_rdata, er);
                default: chk("R8 unused offset", bus_rdata, er);
            endcase
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic look(logic [2:0] a);
        bus_addr = a;
        step();
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // Reset state, all offsets (R1, R5, R7, R8)
        for (int a = 0; a < 8; a++) look(a[2:0]);
        // R8: writes to reserved bits and unused offsets are ignored
        wr(3'd1, 16'hFFFF); wr(3'd3, 16'hFFFF); wr(3'd7, 16'hFFFF);
        look(3'd0); look(3'd2); look(3'd4);
        // R1: pins 1 and 3 outputs, junk in reserved bits
        wr(3'd0, 16'hFAFF);
        // R2: latch written for all pins
        wr(3'd2, 16'h0F00);
        // R3/R4: mixed read with pin levels
        look(3'd2);
        pin_in = 4'b0000; repeat (3) step();
        pin_in = 4'b0101; repeat (3) step();
        pin_in = 4'b1010; repeat (3) step();
        // R7: enable all; R5: falling edges on all pins, only inputs count
        wr(3'd4, 16'h0F00);
        look(3'd6);
        pin_in = 4'b1111; repeat (4) step();
        pin_in = 4'b0000; repeat (4) step();
        // R6: writing zero does nothing, writing one clears
        wr(3'd6, 16'h0000); look(3'd6);
        wr(3'd6, 16'h0100); look(3'd6);
        wr(3'd6, 16'h0F00); look(3'd6);
        // R6: clear coincides with a new edge on pin 2
        pin_in = 4'b0100; repeat (4) step();
        pin_in = 4'b0000; step(); step();
        wr(3'd6, 16'h0400); look(3'd6); step();
        wr(3'd6, 16'h0F00);
        // R7: disable enables while pending
        pin_in = 4'b0001; repeat (3) step();
        pin_in = 4'b0000; repeat (4) step();
        wr(3'd4, 16'h0000); look(3'd6);
        wr(3'd4, 16'h0100); look(3'd6);
        wr(3'd6, 16'h0F00);
        // R9: refresh mode on pin 0, even when pin 0 is an output
        wr(3'd0, 16'h0100);
        refresh_mode = 1'b1;
        look(3'd2);
        pin_in = 4'b0001; repeat (4) step();
        pin_in = 4'b0000; repeat (4) step();
        look(3'd6);
        refresh_mode = 1'b0; repeat (3) step();
        // Random mix across all features
        for (int n = 0; n < 600; n++) begin
            pin_in = $urandom_range(0, 15);
            if ($urandom_range(0, 19) == 0) refresh_mode = ~refresh_mode;
            if ($urandom_range(0, 2) == 0)
                wr($urandom_range(0, 7), 16'($urandom_range(0, 65535)));
            else
                look($urandom_range(0, 7));
        end
        repeat (4) step();
        finish_run();
    end

    initial begin
        #50000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end
endmodule